// File: doc/BRIEF.md
# Free-Running Compare Timer with Toggle Outputs

The block holds a 16-bit up-counter that advances by one on every cycle where the count-tick input is high while the timer is running. Two compare channels watch the counter. When the counter lands on a channel's compare value, that channel gives a one-cycle match pulse and flips its toggle output. When the counter rolls over from all ones to zero, the block gives a one-cycle overflow pulse and sets a sticky overflow flag. The flag stays set until software clears it.

Software drives the block through one register write port. Address 0 is the control word: bit 0 is the run enable and bit 1 is a clear strobe for the overflow flag. Addresses 1 and 2 hold the compare values of channel 0 and channel 1. A write to address 3 has no effect. Starting the timer flips both toggle outputs once. Compare values can be rewritten while the timer runs and are used straight away, with no shadow copy. The current count is brought out so it can be observed.

Top module: `cmp_timer`

## Requirements
- R1: After reset, count is 0, both toggle outputs are 0, all pulses are 0, the overflow flag is 0 and both compare registers hold 16'hFFFF.
- R2: A write to address 0 with bit 0 set, made while the timer is stopped, starts the timer and inverts both toggle outputs at that clock edge. The same write made while the timer is already running leaves the toggles unchanged.
- R3: While running, each cycle with tick high increments count by one, and 16'hFFFF steps to 16'h0000. Cycles with tick low leave count unchanged.
- R4: On a running tick cycle where count+1 equals channel i's compare value, match_pulse[i] is high for the single following cycle. toggle_out[i] inverts at the same edge.
- R5: On a running tick cycle where count is 16'hFFFF, ovf_pulse is high for the following cycle and ovf_flag becomes 1.
- R6: ovf_flag stays 1 until a write to address 0 with bit 1 set. That write clears the flag at its clock edge, and bit 0 of the same write still sets the run enable.
- R7: If a wrap and a flag-clear write fall in the same cycle, ovf_flag ends up 1.
- R8: A write to address 0 with bit 0 clear stops the timer. From the next cycle on, count reads 0, no match or overflow pulse occurs, and the toggle outputs hold their levels whatever tick does.
- R9: A write to address 1 or 2 changes that channel's compare value, and the new value is used from the following cycle's comparison, even mid-count.
- R10: The two channels are independent: a match on one channel neither pulses nor toggles the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 compare ch0, 2 compare ch1 |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count enable tick |
| count | output | 16 | Current counter value |
| toggle_out | output | 2 | Per-channel toggle outputs |
| match_pulse | output | 2 | Per-channel one-cycle match pulses |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench runs one full pass of 65,536 ticks. It checks that the default compare value of 16'hFFFF matches on the way up and that the rollover gives exactly one overflow pulse. A design that compared against the old count, or that wrapped a cycle late, would shift every pulse by one cycle. Right at the rollover the bench issues a flag-clear write to hit the set-versus-clear collision; a design that let the clear win would lose that overflow. Random phases rewrite compare values a few counts ahead of the counter and stop and restart the timer. These phases catch stale compare values, toggles that miss the start inversion, and a counter that keeps moving or pulsing while stopped.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           tick,
  output logic [W-1:0]   count,
  output logic [NCH-1:0] toggle_out,
  output logic [NCH-1:0] match_pulse,
  output logic           ovf_pulse,
  output logic           ovf_flag
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         run;
  logic         ctl_wr, start, clr, act, wrap;
  logic [W-1:0] nxt;

  assign ctl_wr = wr_en && (wr_addr == 2'd0);
  assign start  = ctl_wr && wr_data[0] && !run;
  assign clr    = ctl_wr && wr_data[1];
  assign act    = run && tick;
  assign nxt    = count + 1'b1;
  assign wrap   = act && (count == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else if (ctl_wr) run <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (!run) count <= '0;
    else if (tick) count <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_pulse <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      ovf_flag  <= wrap | (ovf_flag & ~clr);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] cmp;
    logic         hit;

    assign hit = act && (nxt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp <= MAXV;
      else if (wr_en && (wr_addr == 2'(i + 1))) cmp <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_pulse[i] <= 1'b0;
        toggle_out[i]  <= 1'b0;
      end else begin
        match_pulse[i] <= hit;
        toggle_out[i]  <= toggle_out[i] ^ (hit | start);
      end
    end

    // R4: a match pulse always comes with a flip of the same channel's output
    a_r4_match_flips: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse[i] |-> (toggle_out[i] != $past(toggle_out[i])));

    // R8: a stopped timer produces no match
    a_r8_no_match_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !match_pulse[i]);
  end

  // R5: an overflow pulse always leaves the flag set
  a_r5_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_flag);

  // R3: the overflow pulse shows up with the counter back at zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count == '0));

  // R6: without a clear the flag never drops
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr) |=> ovf_flag);

  // R7: a set in the same cycle as a clear wins
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && clr) |=> ovf_flag);

  // R8: a stopped timer holds the counter at zero one cycle later
  a_r8_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0) && !ovf_pulse);

endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [15:0] count;
  logic [1:0]  toggle_out, match_pulse;
  logic        ovf_pulse, ovf_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic        m_run = 1'b0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_cmp [2];
  logic [1:0]  m_tog = '0, m_match = '0;
  logic        m_ovf = 1'b0, m_flag = 1'b0;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .count(count), .toggle_out(toggle_out), .match_pulse(match_pulse),
    .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] inc16(input logic [15:0] v);
    return v + 16'd1;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "count", count, m_cnt);
    chk(tag, "toggle_out", {14'd0, toggle_out}, {14'd0, m_tog});
    chk(tag, "match_pulse", {14'd0, match_pulse}, {14'd0, m_match});
    chk(tag, "ovf_pulse", {15'd0, ovf_pulse}, {15'd0, m_ovf});
    chk(tag, "ovf_flag", {15'd0, ovf_flag}, {15'd0, m_flag});
  endtask

  // one clock: drive inputs, advance the model, compare after the edge
  task automatic step(input logic w, input logic [1:0] a, input logic [15:0] d, input logic t, input string tag);
    logic start, clr, act, wrap;
    logic [15:0] nx;
    logic [1:0] hit;
    wr_en = w; wr_addr = a; wr_data = d; tick = t;
    start = w && a == 2'd0 && d[0] && !m_run;
    clr   = w && a == 2'd0 && d[1];
    act   = m_run && t;
    nx    = inc16(m_cnt);
    wrap  = act && m_cnt == 16'hFFFF;
    for (int i = 0; i < 2; i++) hit[i] = act && nx == m_cmp[i];
    m_match = hit;
    m_tog   = m_tog ^ hit ^ {2{start}};
    m_ovf   = wrap;
    m_flag  = wrap | (m_flag & ~clr);
    m_cnt   = !m_run ? 16'd0 : (t ? nx : m_cnt);
    if (w && a == 2'd1) m_cmp[0] = d;
    if (w && a == 2'd2) m_cmp[1] = d;
    if (w && a == 2'd0) m_run = d[0];
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <= 190000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'h5eed_c0de));
    m_cmp[0] = 16'hFFFF; m_cmp[1] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R8: ticks while stopped do nothing
    for (int k = 0; k < 5; k++) step(1'b0, 2'd0, 16'd0, 1'b1, "R8");
    // R2: start inverts both toggles
    step(1'b1, 2'd0, 16'h0001, 1'b0, "R2");
    chk("R2", "toggle after start", {14'd0, toggle_out}, 16'h0003);
    // R2: rewrite while running does not toggle
    step(1'b1, 2'd0, 16'h0001, 1'b1, "R2");
    // R9/R10: compare ch0 just ahead, ch1 further
    step(1'b1, 2'd1, 16'h0003, 1'b1, "R9");
    step(1'b1, 2'd2, 16'h0006, 1'b1, "R10");
    for (int k = 0; k < 6; k++) step(1'b0, 2'd0, 16'd0, 1'b1, "R10");
    // R9: restore defaults, then run one full pass to the wrap
    step(1'b1, 2'd1, 16'hFFFF, 1'b1, "R9");
    step(1'b1, 2'd2, 16'hFFFF, 1'b0, "R9");
    pulses = 0;
    for (int k = 0; k < 65540; k++) begin
      if (m_cnt == 16'hFFFF) begin
        step(1'b1, 2'd0, 16'h0003, 1'b1, "R7");
        chk("R7", "flag after set/clear clash", {15'd0, ovf_flag}, 16'd1);
      end else begin
        step(1'b0, 2'd0, 16'd0, 1'b1, "R3");
      end
      if (ovf_pulse) pulses++;
    end
    chk("R5", "overflow pulses in one pass", 16'(pulses), 16'd1);
    for (int k = 0; k < 4; k++) step(1'b0, 2'd0, 16'd0, 1'b1, "R6");
    step(1'b1, 2'd0, 16'h0003, 1'b1, "R6");
    chk("R6", "flag after clear", {15'd0, ovf_flag}, 16'd0);

    // random phase
    for (int k = 0; k < 20000; k++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 6)       step(1'b1, 2'd1, m_cnt + 16'($urandom % 8), 1'($urandom), "R9");
      else if (r < 12) step(1'b1, 2'd2, m_cnt + 16'($urandom % 8), 1'($urandom), "R9");
      else if (r < 14) step(1'b1, 2'd0, {14'd0, 1'($urandom % 4 == 0), 1'($urandom % 3 != 0)}, 1'($urandom), "R8");
      else if (r < 15) step(1'b1, 2'd3, 16'($urandom), 1'($urandom), "R4");
      else             step(1'b0, 2'd0, 16'd0, 1'($urandom), "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule